// File: doc/BRIEF.md
# Operand Forwarding Unit

This block picks, for each of the two ALU source operands in the execute stage of a five-stage pipeline, where the operand value should come from. The choices are the value read from the register file, the ALU result currently in the EX/MEM pipeline register, or the value about to be written back from MEM/WB. The block is purely combinational. It compares each producer's destination register field with each consumer's source register field, and raises a forward only when that producer will actually write a register.

Two producers are compared against two sources, which gives four comparisons. A match against the EX/MEM destination beats a match against the MEM/WB destination, because the EX/MEM value is the more recent one. A dependency three instructions back is not handled here. The register file covers that case by writing early in the cycle and reading late in it. Stalling for load-use cases is also left to other logic.

Top module: `fwd_unit`

## Requirements
- R1: When neither producer has its write enable set, both selects are 2'b00 (register file).
- R2: When the EX/MEM producer writes a nonzero register equal to the first source (rs), the first-operand select is 2'b10.
- R3: When the EX/MEM producer writes a nonzero register equal to the second source (rt), the second-operand select is 2'b10.
- R4: When only the MEM/WB producer writes a nonzero register equal to rs, the first-operand select is 2'b01.
- R5: When only the MEM/WB producer writes a nonzero register equal to rt, the second-operand select is 2'b01.
- R6: When both producers match the same source, that operand's select is 2'b10 (the EX/MEM value wins).
- R7: A producer whose destination is register 0 never causes a forward, even when the source field is also 0.
- R8: A producer with its write enable low never causes a forward, even when its destination equals a source.
- R9: When rs equals rt and both producers target that register, both selects are 2'b10 at the same time.
- R10: Neither select ever takes the value 2'b11.
- R11: Each select depends only on its own source field. A match on rt alone leaves the first-operand select at 2'b00, and a match on rs alone leaves the second-operand select at 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs | input | AW | First source register of the instruction in execute |
| ex_rt | input | AW | Second source register of the instruction in execute |
| mem_dst | input | AW | Destination register held in EX/MEM |
| mem_we | input | 1 | Register write enable held in EX/MEM |
| wb_dst | input | AW | Destination register held in MEM/WB |
| wb_we | input | 1 | Register write enable held in MEM/WB |
| sel_a | output | 2 | First-operand source: 00 register file, 10 EX/MEM, 01 MEM/WB |
| sel_b | output | 2 | Second-operand source: 00 register file, 10 EX/MEM, 01 MEM/WB |

## Verification
The hardest case to reach is the one where all four comparisons are true at once. That needs rs equal to rt, and both producers writing that same nonzero register. A dedicated scenario sets up exactly this, so the priority logic on both operands is exercised in the same vector. Register 0 matched with enables high, and matches with enables low, are covered by their own scenarios. In each of those cases every field lines up, so a missing qualifier would show at the selects.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_EXM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_match.sv
// One producer/consumer comparison: the producer must write a nonzero register
module fwd_match #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] dst,
  input  logic          we,
  input  logic [AW-1:0] src,
  output logic          hit
);
  always_comb begin
    hit = we && (dst != '0) && (dst == src);
  end
endmodule

// File: rtl/fwd_pick.sv
// Priority choice for one operand: the newer producer wins
module fwd_pick
  import fwd_pkg::*;
(
  input  logic     hit_new,
  input  logic     hit_old,
  output fwd_sel_e sel
);
  always_comb begin
    if (hit_new)      sel = FWD_EXM;
    else if (hit_old) sel = FWD_WB;
    else              sel = FWD_RF;
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] ex_rs,
  input  logic [AW-1:0] ex_rt,
  input  logic [AW-1:0] mem_dst,
  input  logic          mem_we,
  input  logic [AW-1:0] wb_dst,
  input  logic          wb_we,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b
);
  localparam int NSRC = 2;

  logic [AW-1:0] src_v   [NSRC];
  logic          hit_mem [NSRC];
  logic          hit_wb  [NSRC];
  fwd_sel_e      sel_v   [NSRC];

  assign src_v[0] = ex_rs;
  assign src_v[1] = ex_rt;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    fwd_match #(.AW(AW)) u_mem (
      .dst(mem_dst), .we(mem_we), .src(src_v[g]), .hit(hit_mem[g])
    );
    fwd_match #(.AW(AW)) u_wb (
      .dst(wb_dst), .we(wb_we), .src(src_v[g]), .hit(hit_wb[g])
    );
    fwd_pick u_pick (
      .hit_new(hit_mem[g]), .hit_old(hit_wb[g]), .sel(sel_v[g])
    );
  end

  assign sel_a = sel_v[0];
  assign sel_b = sel_v[1];
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int AW = 5
) (
  input logic [AW-1:0] ex_rs,
  input logic [AW-1:0] ex_rt,
  input logic [AW-1:0] mem_dst,
  input logic          mem_we,
  input logic [AW-1:0] wb_dst,
  input logic          wb_we,
  input logic [1:0]    sel_a,
  input logic [1:0]    sel_b
);
  always_comb begin
    assert_no_code3_R10: assert (sel_a != 2'b11 && sel_b != 2'b11)
      else $error("select code 11 seen");
    assert_idle_rf_R1: assert (mem_we || wb_we || (sel_a == 2'b00 && sel_b == 2'b00))
      else $error("forward with no writer");
    assert_zero_reg_R7: assert (ex_rs != '0 || sel_a == 2'b00)
      else $error("register 0 forwarded on rs");
    assert_newer_wins_R6: assert (!(mem_we && mem_dst != '0 && mem_dst == ex_rs) || sel_a == 2'b10)
      else $error("EX/MEM match on rs not taken");
    assert_newer_wins_b_R3: assert (!(mem_we && mem_dst != '0 && mem_dst == ex_rt) || sel_b == 2'b10)
      else $error("EX/MEM match on rt not taken");
  end
endmodule

bind fwd_unit fwd_unit_chk #(.AW(AW)) u_chk (
  .ex_rs(ex_rs), .ex_rt(ex_rt), .mem_dst(mem_dst), .mem_we(mem_we),
  .wb_dst(wb_dst), .wb_we(wb_we), .sel_a(sel_a), .sel_b(sel_b)
);

// File: tb/sim_fwd_unit.sv
module sim_fwd_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] rs, rt, mdst, wdst;
  logic       mwe, wwe;
  logic [1:0] sa, sb;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  fwd_unit u0 (
    .ex_rs(rs), .ex_rt(rt), .mem_dst(mdst), .mem_we(mwe),
    .wb_dst(wdst), .wb_we(wwe), .sel_a(sa), .sel_b(sb)
  );

  task automatic drive(input logic [4:0] a, b, md, input logic me,
                       input logic [4:0] wd, input logic we);
    @(negedge clk);
    rs = a; rt = b; mdst = md; mwe = me; wdst = wd; wwe = we;
    #2;
  endtask

  task automatic chk(input string req, input logic [1:0] ea, eb);
    n_chk++;
    if (sa !== ea || sb !== eb) begin
      n_bad++;
      $display("FAIL %s: sel_a=%b sel_b=%b expected %b %b", req, sa, sb, ea, eb);
    end
  endtask

  task automatic t_idle();      // R1
    drive(5'd3, 5'd4, 5'd3, 1'b0, 5'd4, 1'b0); chk("R1", 2'b00, 2'b00);
    drive(5'd0, 5'd0, 5'd9, 1'b0, 5'd9, 1'b0); chk("R1", 2'b00, 2'b00);
  endtask

  task automatic t_exmem();     // R2 R3 R11
    drive(5'd2, 5'd5, 5'd2, 1'b1, 5'd7, 1'b1); chk("R2", 2'b10, 2'b00);
    drive(5'd1, 5'd2, 5'd2, 1'b1, 5'd7, 1'b0); chk("R3", 2'b00, 2'b10);
    drive(5'd8, 5'd6, 5'd6, 1'b1, 5'd0, 1'b0); chk("R11", 2'b00, 2'b10);
  endtask

  task automatic t_memwb();     // R4 R5 R11
    drive(5'd2, 5'd1, 5'd9, 1'b1, 5'd2, 1'b1); chk("R4", 2'b01, 2'b00);
    drive(5'd6, 5'd2, 5'd9, 1'b0, 5'd2, 1'b1); chk("R5", 2'b00, 2'b01);
    drive(5'd31, 5'd1, 5'd4, 1'b0, 5'd31, 1'b1); chk("R11", 2'b01, 2'b00);
  endtask

  task automatic t_prio();      // R6 R9
    drive(5'd2, 5'd2, 5'd2, 1'b1, 5'd2, 1'b1); chk("R9", 2'b10, 2'b10);
    drive(5'd4, 5'd7, 5'd4, 1'b1, 5'd4, 1'b1); chk("R6", 2'b10, 2'b00);
    drive(5'd4, 5'd7, 5'd7, 1'b1, 5'd4, 1'b1); chk("R6", 2'b01, 2'b10);
  endtask

  task automatic t_qual();      // R7 R8 R10
    drive(5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1); chk("R7", 2'b00, 2'b00);
    drive(5'd0, 5'd3, 5'd0, 1'b1, 5'd3, 1'b1); chk("R7", 2'b00, 2'b01);
    drive(5'd5, 5'd5, 5'd5, 1'b0, 5'd5, 1'b0); chk("R8", 2'b00, 2'b00);
    drive(5'd5, 5'd6, 5'd5, 1'b0, 5'd5, 1'b1); chk("R8", 2'b01, 2'b00);
    drive(5'd9, 5'd9, 5'd9, 1'b1, 5'd0, 1'b1); chk("R10", 2'b10, 2'b10);
  endtask

  initial begin
    rs = '0; rt = '0; mdst = '0; mwe = 1'b0; wdst = '0; wwe = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    #2;
    chk("R1", 2'b00, 2'b00);
    t_idle();
    t_exmem();
    t_memwb();
    t_prio();
    t_qual();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule